// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for a synchronous memory that serves four-beat bursts. A burst opens when either of two active-low start strobes is sampled low: one meant for a processor, one for a cache controller. The external address is then captured as the burst start. Each later clock edge that samples the active-low advance input moves a 2-bit beat counter forward. The two low address bits are derived from the captured start bits and that counter. The upper bits stay at their captured value.

A static ordering input picks the beat order. Low selects linear order: the start plus the beat number, modulo four. High selects interleaved order: the start XOR the beat number. The address and a final-beat flag come straight from registers. Each therefore reflects the inputs sampled at the previous rising edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the registered outputs become `addr_out` = 0 and `last_beat` = 0 after that edge.
- R2: When `start_cpu_n` or `start_ctl_n` is sampled low, `addr_out` equals the sampled `addr_in` after that edge, `last_beat` is 0, and the beat count restarts at 0. This also applies in the middle of a burst.
- R3: A start strobe takes precedence over `advance_n`. With both strobes low, or a strobe and `advance_n` low together, a single fresh start is made and no step is taken. In the internal selection the processor strobe ranks above the controller strobe.
- R4: With `order_sel` = 0 (linear), `addr_out[1:0]` equals (start low bits + beat) mod 4. For example, start 1 gives 1,2,3,0.
- R5: With `order_sel` = 1 (interleaved), `addr_out[1:0]` equals (start low bits) XOR beat. For example, start 2 gives 2,3,0,1.
- R6: `addr_out[AW-1:2]` never changes between starts, including when the beat count wraps from 3 to 0.
- R7: When both strobes and `advance_n` are sampled high, and `order_sel` is unchanged, `addr_out` and `last_beat` hold their values whatever `addr_in` carries.
- R8: `last_beat` is 1 exactly when the beat count is 3. One further advance wraps the count to 0 and clears the flag.
- R9: Every output change appears one rising edge after the input that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_cpu_n | input | 1 | Processor-side burst start, active low |
| start_ctl_n | input | 1 | Controller-side burst start, active low |
| advance_n | input | 1 | Step to next beat, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | AW | External start address |
| addr_out | output | AW | Current burst word address (registered) |
| last_beat | output | 1 | High on the fourth beat of a burst (registered) |

## Verification
The block has exactly one register stage between its inputs and outputs. Every address or flag result is therefore due one rising edge after the strobe, advance or idle cycle that causes it. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares on the next falling edge, before any new stimulus takes effect. Reset results follow the same one-edge rule.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    ACT_HOLD     = 2'd0,
    ACT_LOAD_CPU = 2'd1,
    ACT_LOAD_CTL = 2'd2,
    ACT_STEP     = 2'd3
  } burst_act_e;

endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl
  import burst_pkg::*;
(
  input  logic       start_cpu_n,
  input  logic       start_ctl_n,
  input  logic       advance_n,
  output burst_act_e act
);

  // Processor strobe outranks controller strobe; any start outranks a step.
  always_comb begin
    if (!start_cpu_n)      act = ACT_LOAD_CPU;
    else if (!start_ctl_n) act = ACT_LOAD_CTL;
    else if (!advance_n)   act = ACT_STEP;
    else                   act = ACT_HOLD;
  end

endmodule

// File: rtl/burst_state_regs.sv
module burst_state_regs
  import burst_pkg::*;
#(
  parameter int AW    = 17,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  burst_act_e       act,
  input  logic [AW-1:0]    addr_in,
  output logic [AW-1:0]    base_next,
  output logic [CNT_W-1:0] cnt_next
);

  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    base_next = base_q;
    cnt_next  = cnt_q;
    unique case (act)
      ACT_LOAD_CPU,
      ACT_LOAD_CTL: begin
        base_next = addr_in;
        cnt_next  = '0;
      end
      ACT_STEP: cnt_next = cnt_q + 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_next;
      cnt_q  <= cnt_next;
    end
  end

endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
  import burst_pkg::*;
#(
  parameter int AW    = 17,
  parameter int CNT_W = 2
) (
  input  logic [AW-1:0]    base,
  input  logic [CNT_W-1:0] cnt,
  input  burst_order_e     order,
  output logic [AW-1:0]    addr,
  output logic             last
);

  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] low_lin;
  logic [CNT_W-1:0] low_ilv;

  assign low_lin = base[CNT_W-1:0] + cnt;

  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
    assign low_ilv[b] = base[b] ^ cnt[b];
  end

  assign addr = {base[AW-1:CNT_W],
                 (order == ORDER_INTERLEAVE) ? low_ilv : low_lin};
  assign last = (cnt == CNT_LAST);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_cpu_n,
  input  logic          start_ctl_n,
  input  logic          advance_n,
  input  logic          order_sel,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          last_beat
);

  localparam int CNT_W = 2;

  burst_act_e       act;
  logic [AW-1:0]    base_next;
  logic [CNT_W-1:0] cnt_next;
  logic [AW-1:0]    map_addr;
  logic             map_last;
  burst_order_e     order;

  assign order = burst_order_e'(order_sel);

  burst_load_ctrl u_ctrl (
    .start_cpu_n (start_cpu_n),
    .start_ctl_n (start_ctl_n),
    .advance_n   (advance_n),
    .act         (act)
  );

  burst_state_regs #(.AW(AW), .CNT_W(CNT_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .addr_in   (addr_in),
    .base_next (base_next),
    .cnt_next  (cnt_next)
  );

  burst_seq_map #(.AW(AW), .CNT_W(CNT_W)) u_map (
    .base  (base_next),
    .cnt   (cnt_next),
    .order (order),
    .addr  (map_addr),
    .last  (map_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out  <= '0;
      last_beat <= 1'b0;
    end else begin
      addr_out  <= map_addr;
      last_beat <= map_last;
    end
  end

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          start_cpu_n,
  input logic          start_ctl_n,
  input logic          advance_n,
  input logic          order_sel,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic          last_beat
);

  logic any_start;
  logic idle;
  assign any_start = !start_cpu_n || !start_ctl_n;
  assign idle      = start_cpu_n && start_ctl_n && advance_n;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    any_start |=> (addr_out == $past(addr_in)) && !last_beat); // R2

  AST_START_BEATS_STEP: assert property (@(posedge clk) disable iff (rst)
    (any_start && !advance_n) |=> !last_beat); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!any_start && !advance_n && !order_sel && $stable(order_sel))
      |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1); // R4

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    !any_start |=> addr_out[AW-1:2] == $past(addr_out[AW-1:2])); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (idle && $stable(order_sel)) |=> $stable(addr_out) && $stable(last_beat)); // R7

  AST_LAST_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !any_start && !advance_n) |=> !last_beat); // R8

  AST_LAST_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
    (!last_beat && (any_start || advance_n)) |=> !last_beat); // R8

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_cpu_n (start_cpu_n),
  .start_ctl_n (start_ctl_n),
  .advance_n   (advance_n),
  .order_sel   (order_sel),
  .addr_in     (addr_in),
  .addr_out    (addr_out),
  .last_beat   (last_beat)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

  localparam int AW = 17;
  localparam int NV = 18;
  localparam int VW = 4 + AW + AW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_cpu_n = 1'b1;
  logic          start_ctl_n = 1'b1;
  logic          advance_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          last_beat;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n),
    .advance_n(advance_n), .order_sel(order_sel), .addr_in(addr_in),
    .addr_out(addr_out), .last_beat(last_beat)
  );

  // {cpu_n, ctl_n, adv_n, order, addr_in, exp_addr, exp_last}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b0110, 17'h12341, 17'h12341, 1'b0},  // R2 cpu start, linear
    {4'b1100, 17'h00000, 17'h12342, 1'b0},  // R4
    {4'b1100, 17'h00000, 17'h12343, 1'b0},  // R4
    {4'b1100, 17'h00000, 17'h12340, 1'b1},  // R8 R6 wrap of low bits
    {4'b1100, 17'h00000, 17'h12341, 1'b0},  // R8 wraps to beat 0
    {4'b1110, 17'h1FFFF, 17'h12341, 1'b0},  // R7 idle, addr_in ignored
    {4'b1011, 17'h0ABC6, 17'h0ABC6, 1'b0},  // R2 ctl start, interleaved
    {4'b1101, 17'h00000, 17'h0ABC7, 1'b0},  // R5
    {4'b1101, 17'h00000, 17'h0ABC4, 1'b0},  // R5
    {4'b1101, 17'h00000, 17'h0ABC5, 1'b1},  // R5 R8
    {4'b1111, 17'h00123, 17'h0ABC5, 1'b1},  // R7 hold keeps flag
    {4'b0000, 17'h1FFFF, 17'h1FFFF, 1'b0},  // R3 both strobes + advance
    {4'b1100, 17'h00000, 17'h1FFFC, 1'b0},  // R6 upper bits fixed
    {4'b1100, 17'h00000, 17'h1FFFD, 1'b0},  // R4
    {4'b1010, 17'h00003, 17'h00003, 1'b0},  // R2 restart mid-burst
    {4'b1100, 17'h00000, 17'h00000, 1'b0},  // R6 no carry into upper
    {4'b0100, 17'h05552, 17'h05552, 1'b0},  // R3 strobe beats advance
    {4'b1100, 17'h00000, 17'h05553, 1'b0}   // R9 one edge per step
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 6, 14:     return "R2";
      1, 2, 13:     return "R4";
      3, 4, 9:      return "R8";
      5, 10:        return "R7";
      7, 8:         return "R5";
      11, 16:       return "R3";
      12, 15:       return "R6";
      default:      return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [AW-1:0] exp_a, logic exp_l);
    n_cmp++;
    if (addr_out !== exp_a || last_beat !== exp_l) begin
      n_bad++;
      $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b",
               tag, addr_out, last_beat, exp_a, exp_l);
    end
  endtask

  task automatic drive(logic c, logic t, logic a, logic o, logic [AW-1:0] ai);
    start_cpu_n = c; start_ctl_n = t; advance_n = a; order_sel = o; addr_in = ai;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[VW-1], v[VW-2], v[VW-3], v[VW-4], v[2*AW:AW+1]);
      @(negedge clk);
      check(vec_tag(i), v[AW:1], v[0]);
    end
    // R1: reset in the middle of a burst
    drive(1'b1, 1'b1, 1'b0, 1'b0, '0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", '0, 1'b0);
    rst = 1'b0;
    // R9: one advance after reset steps from base 0
    drive(1'b1, 1'b1, 1'b0, 1'b0, 17'h1_0000);
    @(negedge clk);
    check("R9", 17'h00001, 1'b0);
    // R5: interleaved from start 3 gives 3,2,1,0
    drive(1'b0, 1'b1, 1'b1, 1'b1, 17'h0_0F0F);
    @(negedge clk);
    check("R5", 17'h00F0F, 1'b0);
    drive(1'b1, 1'b1, 1'b0, 1'b1, '0);
    @(negedge clk);
    check("R5", 17'h00F0E, 1'b0);
    @(negedge clk);
    check("R5", 17'h00F0D, 1'b0);
    @(negedge clk);
    check("R8", 17'h00F0C, 1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule